// File: doc/BRIEF.md
# Sleep-State Rail Sequencer

This block is the digital control core of a board power manager. It moves a group of dual and standby rails between the running state and two sleep depths: suspend-to-RAM and soft-off. Two active-low sleep request lines select the target state. The block then drives the enables for:

- the pass switches that feed the dual rails from the main supplies when running;
- the standby linear regulators for the 3.3 V dual rail and the memory rail;
- the standby switch that feeds the 5 V dual rail;
- a soft-start ramp request.

Comparators outside the block report standby power-good, undervoltage on each monitored input supply, undervoltage on each controlled output, and two overtemperature levels. The block only sees these as digital flags.

All timing is counted in clock cycles. The counts come from a clock rate in MHz and from intervals in microseconds. The deglitch window is N = CLK_MHZ*GLITCH_US + 1 cycles. The undervoltage persistence is M = CLK_MHZ*UV_US. The sleep entry delay is D = CLK_MHZ*SLEEP_US. The supply qualification is Q = CLK_MHZ*QUAL_US.

The states are OFF, QUAL (qualifying), RUN, DELAY (sleep pending), S3 and S5. A sleep request decodes as follows: sleep-5 line low means S5; otherwise sleep-3 line low means S3; both high means run.

Top module: `rail_seq_ctrl`

## Requirements
- R1: A change on either sleep request line reaches the state machine only after the line has differed from its filtered value for N consecutive cycles, so a pulse of N-1 cycles or fewer has no effect.
- R2: The block never moves directly between S3 and S5. In S3 a soft-off request is ignored, and in S5 a suspend request is ignored. While qualifying after a sleep exit, a request for the other sleep depth is also ignored.
- R3: The 5 V dual sleep-support input is captured in every OFF cycle, which covers standby power-good release and shutdown exit. It is also captured on the DELAY-to-sleep step. A change at any other time does not alter `dual5_sb_sw_en`.
- R4: From QUAL the block enters RUN only after Q consecutive cycles with all `in_uv` bits low and no sleep request. Any `in_uv` bit high restarts the count. RUN is entered Q edges after the QUAL entry edge, or Q edges after the last bad edge.
- R5: A filtered sleep request in RUN moves to DELAY. The sleep state is entered D cycles later. If the request drops during DELAY, the block returns to RUN.
- R6: An undervoltage flag must be high for M consecutive cycles before it counts. The fault output rises one cycle after that, so a pulse of M-1 cycles is ignored.
- R7: `fault` is set by a persisted undervoltage on any input or output while in RUN or DELAY, or by either overtemperature flag in any state. Once set it stays high until it is cleared. An undervoltage in a sleep state does not set it.
- R8: `shdn` high forces OFF on the next edge, with all rail enables low and `fault` cleared.
- R9: `ot_crit` high forces OFF on the next edge, with all rail enables low.
- R10: The rail enables per state are:
  - OFF: all low.
  - QUAL: 3.3 V dual regulator, memory regulator, ramp, and the 5 V dual sleep switch equal to the latched enable.
  - RUN and DELAY: active switches and ramp only.
  - S3: same as QUAL.
  - S5: as S3, but with the memory regulator off.
- R11: With `rst` high, or with `sb_por_ok` low, the block is in OFF with `fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slp3_req_n | input | 1 | Suspend request, active low |
| slp5_req_n | input | 1 | Soft-off request, active low |
| dual5_keep_en | input | 1 | 5 V dual sleep-support enable |
| shdn | input | 1 | Shutdown request, active high |
| sb_por_ok | input | 1 | Standby supply above its power-on threshold |
| in_uv | input | N_IN | Undervoltage flag per monitored input supply |
| out_uv | input | N_OUT | Undervoltage flag per controlled output |
| ot_warn | input | 1 | Overtemperature at the fault level |
| ot_crit | input | 1 | Overtemperature at the shutdown level |
| act_sw_en | output | 1 | Active-state pass switch enable |
| dual3_ldo_en | output | 1 | 3.3 V dual standby regulator enable |
| mem_ldo_en | output | 1 | Memory standby regulator enable |
| dual5_sb_sw_en | output | 1 | 5 V dual standby switch enable |
| ramp_en | output | 1 | Soft-start ramp request |
| fault | output | 1 | Latched fault indication |

## Verification
The assertions check these properties on every cycle:
- each filter output only ever moves to the value its input held on the previous edge;
- S3 and S5 never follow one another;
- the 5 V dual latch stays still outside OFF and sleep entry;
- the active switches only rise after a cycle with all input supplies good;
- shutdown, critical temperature and standby power loss blank the outputs or the fault on the next edge;
- a set fault persists until cleared.

Only the bench scenarios can show the exact cycle counts of the filter, the persistence, the delay and the qualification restart. The glitch-length sweep, the per-flag undervoltage sweep and the ignored sleep-depth changes also need the bench.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_QUAL,
        ST_ACT,
        ST_DLY,
        ST_SLP3,
        ST_SLP5
    } seq_state_e;

    typedef enum logic [1:0] {
        REQ_RUN,
        REQ_S3,
        REQ_S5
    } sleep_req_e;

    typedef struct packed {
        logic act_sw;
        logic dual3_ldo;
        logic mem_ldo;
        logic dual5_sb;
        logic ramp;
    } rail_ctl_t;

    // Width of a counter that must hold values up to n.
    function automatic int unsigned cyc_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Soft-off wins over suspend; both high means run.
    function automatic sleep_req_e decode_req(input logic s3_n, input logic s5_n);
        if (!s5_n) return REQ_S5;
        if (!s3_n) return REQ_S3;
        return REQ_RUN;
    endfunction

    function automatic seq_state_e sleep_state_for(input sleep_req_e r);
        return (r == REQ_S5) ? ST_SLP5 : ST_SLP3;
    endfunction

    function automatic rail_ctl_t rails_for(input seq_state_e s, input logic d5);
        rail_ctl_t r;
        r = '0;
        case (s)
            ST_QUAL, ST_SLP3: begin
                r.dual3_ldo = 1'b1;
                r.mem_ldo   = 1'b1;
                r.dual5_sb  = d5;
                r.ramp      = 1'b1;
            end
            ST_SLP5: begin
                r.dual3_ldo = 1'b1;
                r.dual5_sb  = d5;
                r.ramp      = 1'b1;
            end
            ST_ACT, ST_DLY: begin
                r.act_sw = 1'b1;
                r.ramp   = 1'b1;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/seq_deglitch.sv
module seq_deglitch
    import rail_seq_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 4,
    parameter bit          RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    generate
        if (HOLD_CYC <= 1) begin : g_direct
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= d;
            end
        end else begin : g_count
            localparam int unsigned CW = cyc_width(HOLD_CYC);
            logic [CW-1:0] run_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    q     <= RST_VAL;
                    run_q <= '0;
                end else if (d == q) begin
                    run_q <= '0;
                end else if (run_q == CW'(HOLD_CYC - 1)) begin
                    q     <= d;
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    endgenerate

    // R1: the filtered value only ever adopts what the input held.
    a_r1_follows_input: assert property (@(posedge clk) disable iff (rst)
        (q != $past(q)) |-> ($past(d) == q));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import rail_seq_pkg::*;
#(
    parameter int unsigned QUAL_CYC = 1250000,
    parameter int unsigned DLY_CYC  = 10000
) (
    input  logic       clk,
    input  logic       rst,
    input  sleep_req_e req,
    input  logic       por_ok,
    input  logic       shdn,
    input  logic       ot_crit,
    input  logic       supplies_ok,
    input  logic       dual5_raw,
    output seq_state_e state,
    output logic       dual5_lat
);

    localparam int unsigned CMAX = (QUAL_CYC > DLY_CYC) ? QUAL_CYC : DLY_CYC;
    localparam int unsigned CW   = cyc_width(CMAX);

    seq_state_e    state_q, nxt;
    sleep_req_e    origin_q, origin_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          d5_q, d5_n;
    logic          to_sleep;

    always_comb begin
        nxt      = state_q;
        origin_n = origin_q;
        if (!por_ok || shdn || ot_crit) begin
            nxt = ST_OFF;
        end else begin
            case (state_q)
                ST_OFF: begin
                    if (req == REQ_RUN) begin
                        nxt      = ST_QUAL;
                        origin_n = REQ_RUN;
                    end else begin
                        nxt = sleep_state_for(req);
                    end
                end
                ST_QUAL: begin
                    if (req == REQ_RUN) begin
                        if (supplies_ok && cnt_q == CW'(QUAL_CYC - 1)) nxt = ST_ACT;
                    end else if (origin_q == REQ_RUN || req == origin_q) begin
                        nxt = sleep_state_for(req);
                    end
                end
                ST_ACT: begin
                    if (req != REQ_RUN) nxt = ST_DLY;
                end
                ST_DLY: begin
                    if (req == REQ_RUN)                      nxt = ST_ACT;
                    else if (cnt_q == CW'(DLY_CYC - 1))      nxt = sleep_state_for(req);
                end
                ST_SLP3: begin
                    if (req == REQ_RUN) begin
                        nxt      = ST_QUAL;
                        origin_n = REQ_S3;
                    end
                end
                ST_SLP5: begin
                    if (req == REQ_RUN) begin
                        nxt      = ST_QUAL;
                        origin_n = REQ_S5;
                    end
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_comb begin
        cnt_n = '0;
        if (nxt == state_q) begin
            if ((state_q == ST_QUAL && req == REQ_RUN && supplies_ok) || state_q == ST_DLY)
                cnt_n = cnt_q + 1'b1;
        end
    end

    assign to_sleep = (state_q == ST_DLY) && (nxt == ST_SLP3 || nxt == ST_SLP5);

    always_comb begin
        d5_n = d5_q;
        if (state_q == ST_OFF || to_sleep) d5_n = dual5_raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_OFF;
            origin_q <= REQ_RUN;
            cnt_q    <= '0;
            d5_q     <= 1'b0;
        end else begin
            state_q  <= nxt;
            origin_q <= origin_n;
            cnt_q    <= cnt_n;
            d5_q     <= d5_n;
        end
    end

    assign state     = state_q;
    assign dual5_lat = d5_q;

    // R2: the two sleep depths never follow one another.
    a_r2_no_s3_to_s5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLP3) |=> (state_q != ST_SLP5));
    a_r2_no_s5_to_s3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLP5) |=> (state_q != ST_SLP3));

    // R3: the sleep-support latch holds outside OFF and sleep entry.
    a_r3_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACT || state_q == ST_QUAL || state_q == ST_SLP3 || state_q == ST_SLP5)
        |=> (d5_q == $past(d5_q)));

endmodule

// File: rtl/seq_fault_keeper.sv
module seq_fault_keeper #(
    parameter int unsigned N_MON = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_MON-1:0] uv_f,
    input  logic             armed,
    input  logic             ot_warn,
    input  logic             ot_crit,
    input  logic             clr,
    output logic             fault
);

    logic fault_q;
    logic hit;

    assign hit = (armed && (|uv_f)) || ot_warn || ot_crit;

    always_ff @(posedge clk) begin
        if (rst)       fault_q <= 1'b0;
        else if (clr)  fault_q <= 1'b0;
        else if (hit)  fault_q <= 1'b1;
    end

    assign fault = fault_q;

    // R7: once raised, the fault stays until a clear arrives.
    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        (fault_q && !clr) |=> fault_q);

    // R11 / R8: a clear input empties the fault on the next edge.
    a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> !fault_q);

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
    import rail_seq_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 50,
    parameter int unsigned GLITCH_US = 2,
    parameter int unsigned UV_US     = 10,
    parameter int unsigned SLEEP_US  = 200,
    parameter int unsigned QUAL_US   = 25000,
    parameter int unsigned N_IN      = 3,
    parameter int unsigned N_OUT     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slp3_req_n,
    input  logic             slp5_req_n,
    input  logic             dual5_keep_en,
    input  logic             shdn,
    input  logic             sb_por_ok,
    input  logic [N_IN-1:0]  in_uv,
    input  logic [N_OUT-1:0] out_uv,
    input  logic             ot_warn,
    input  logic             ot_crit,
    output logic             act_sw_en,
    output logic             dual3_ldo_en,
    output logic             mem_ldo_en,
    output logic             dual5_sb_sw_en,
    output logic             ramp_en,
    output logic             fault
);

    localparam int unsigned GL_CYC   = CLK_MHZ * GLITCH_US + 1;
    localparam int unsigned UV_CYC   = CLK_MHZ * UV_US;
    localparam int unsigned DLY_CYC  = CLK_MHZ * SLEEP_US;
    localparam int unsigned QUAL_CYC = CLK_MHZ * QUAL_US;
    localparam int unsigned N_MON    = N_IN + N_OUT;

    logic [1:0]       slp_raw, slp_f;
    logic [N_MON-1:0] uv_raw, uv_f;
    sleep_req_e       req;
    seq_state_e       state;
    logic             d5_lat;
    rail_ctl_t        rails;

    assign slp_raw = {slp5_req_n, slp3_req_n};
    assign uv_raw  = {out_uv, in_uv};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_slp_filt
            seq_deglitch #(.HOLD_CYC(GL_CYC), .RST_VAL(1'b1)) u_filt (
                .clk(clk), .rst(rst), .d(slp_raw[g]), .q(slp_f[g])
            );
        end
        for (genvar m = 0; m < N_MON; m++) begin : g_uv_filt
            seq_deglitch #(.HOLD_CYC(UV_CYC), .RST_VAL(1'b0)) u_filt (
                .clk(clk), .rst(rst), .d(uv_raw[m]), .q(uv_f[m])
            );
        end
    endgenerate

    assign req = decode_req(slp_f[0], slp_f[1]);

    seq_fsm #(.QUAL_CYC(QUAL_CYC), .DLY_CYC(DLY_CYC)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .por_ok     (sb_por_ok),
        .shdn       (shdn),
        .ot_crit    (ot_crit),
        .supplies_ok(in_uv == '0),
        .dual5_raw  (dual5_keep_en),
        .state      (state),
        .dual5_lat  (d5_lat)
    );

    seq_fault_keeper #(.N_MON(N_MON)) u_fault (
        .clk    (clk),
        .rst    (rst),
        .uv_f   (uv_f),
        .armed  (state == ST_ACT || state == ST_DLY),
        .ot_warn(ot_warn),
        .ot_crit(ot_crit),
        .clr    (shdn || !sb_por_ok),
        .fault  (fault)
    );

    assign rails          = rails_for(state, d5_lat);
    assign act_sw_en      = rails.act_sw;
    assign dual3_ldo_en   = rails.dual3_ldo;
    assign mem_ldo_en     = rails.mem_ldo;
    assign dual5_sb_sw_en = rails.dual5_sb;
    assign ramp_en        = rails.ramp;

    // R4: switches come on only after a cycle with every input supply good.
    a_r4_act_needs_good: assert property (@(posedge clk) disable iff (rst)
        $rose(act_sw_en) |-> ($past(in_uv) == '0));

    // R8: shutdown blanks every rail and the fault on the next edge.
    a_r8_shdn_blanks: assert property (@(posedge clk) disable iff (rst)
        shdn |=> (!act_sw_en && !dual3_ldo_en && !mem_ldo_en && !dual5_sb_sw_en
                  && !ramp_en && !fault));

    // R9: critical temperature blanks every rail on the next edge.
    a_r9_crit_blanks: assert property (@(posedge clk) disable iff (rst)
        ot_crit |=> (!act_sw_en && !dual3_ldo_en && !mem_ldo_en && !dual5_sb_sw_en
                     && !ramp_en));

endmodule

// File: tb/rail_seq_ctrl_test.sv
module rail_seq_ctrl_test;

    localparam int unsigned CLKM = 1;
    localparam int unsigned GUS  = 3;
    localparam int unsigned UUS  = 5;
    localparam int unsigned SUS  = 2;
    localparam int unsigned QUS  = 30;
    localparam int unsigned NI   = 3;
    localparam int unsigned NO   = 5;
    localparam int GLC  = CLKM * GUS + 1;
    localparam int UVC  = CLKM * UUS;
    localparam int DLYC = CLKM * SUS;
    localparam int QC   = CLKM * QUS;

    logic clk = 1'b0;
    logic rst, slp3, slp5, d5, shdn, por, otw, otc;
    logic [NI-1:0] in_uv;
    logic [NO-1:0] out_uv;
    logic act, dual3, mem, d5sb, ramp, fault;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rail_seq_ctrl #(
        .CLK_MHZ(CLKM), .GLITCH_US(GUS), .UV_US(UUS), .SLEEP_US(SUS),
        .QUAL_US(QUS), .N_IN(NI), .N_OUT(NO)
    ) uut (
        .clk(clk), .rst(rst), .slp3_req_n(slp3), .slp5_req_n(slp5),
        .dual5_keep_en(d5), .shdn(shdn), .sb_por_ok(por), .in_uv(in_uv),
        .out_uv(out_uv), .ot_warn(otw), .ot_crit(otc), .act_sw_en(act),
        .dual3_ldo_en(dual3), .mem_ldo_en(mem), .dual5_sb_sw_en(d5sb),
        .ramp_en(ramp), .fault(fault)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int actual, input int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; slp3 = 1; slp5 = 1; d5 = 1; shdn = 0; por = 1;
        otw = 0; otc = 0; in_uv = '0; out_uv = '0;
        tick(3);
        // R11 reset state, R10 OFF encoding
        chk("R11 reset act", int'(act), 0);
        chk("R11 reset fault", int'(fault), 0);
        chk("R10 OFF ramp", int'(ramp), 0);

        // R4 qualification from reset release
        rst = 0;
        tick(QC);
        chk("R4 not yet active", int'(act), 0);
        chk("R10 QUAL mem", int'(mem), 1);
        tick(1);
        chk("R4 active at Q", int'(act), 1);
        chk("R10 RUN dual3 off", int'(dual3), 0);
        chk("R10 RUN ramp", int'(ramp), 1);

        // R5 exact sleep delay, R3 capture at sleep entry
        slp3 = 0;
        tick(GLC + DLYC);
        chk("R5 still active", int'(act), 1);
        tick(1);
        chk("R5 sleep entered", int'(act), 0);
        chk("R10 S3 mem", int'(mem), 1);
        chk("R10 S3 dual3", int'(dual3), 1);
        chk("R3 latched at entry", int'(d5sb), 1);
        d5 = 0;
        tick(5);
        chk("R3 ignored in sleep", int'(d5sb), 1);

        // R2 S3 to S5 blocked
        slp5 = 0;
        tick(GLC + DLYC + 5);
        chk("R2 S3 holds against S5", int'(mem), 1);
        slp3 = 1; slp5 = 1;
        tick(GLC + 2);
        chk("R2 in QUAL", int'(act), 0);
        slp3 = 0; slp5 = 0;
        tick(GLC + 10);
        chk("R2 QUAL ignores S5 after S3", int'(mem), 1);
        slp3 = 1; slp5 = 1;
        tick(GLC + QC + 3);
        chk("R4 active after wake", int'(act), 1);

        // R3 capture of a low enable, R10 S5 encoding
        d5 = 0;
        slp3 = 0; slp5 = 0;
        tick(GLC + DLYC + 2);
        chk("R10 S5 act", int'(act), 0);
        chk("R10 S5 mem off", int'(mem), 0);
        chk("R10 S5 dual3", int'(dual3), 1);
        chk("R3 latched low", int'(d5sb), 0);
        d5 = 1;
        tick(3);
        chk("R3 ignored in S5", int'(d5sb), 0);
        slp5 = 1;
        tick(GLC + 5);
        chk("R2 S5 holds against S3", int'(mem), 0);
        slp3 = 1;
        tick(GLC + QC + 3);
        chk("R4 active after S5", int'(act), 1);

        // R1 glitch-length sweep on both lines
        for (int ln = 0; ln < 2; ln++) begin
            for (int len = 1; len <= GLC + 1; len++) begin
                logic seen;
                seen = 1'b0;
                if (ln == 0) slp3 = 0; else slp5 = 0;
                for (int c = 0; c < len; c++) begin
                    tick(1);
                    if (!act) seen = 1'b1;
                end
                slp3 = 1; slp5 = 1;
                for (int c = 0; c < 2 * GLC + DLYC + 6; c++) begin
                    tick(1);
                    if (!act) seen = 1'b1;
                end
                chk($sformatf("R1 line%0d len%0d", ln, len), int'(seen), (len >= GLC) ? 1 : 0);
                tick(QC + 2 * GLC + 5);
                chk("R1 recovered", int'(act), 1);
            end
        end

        // R6 persistence and R7 latching, per monitored flag
        for (int b = 0; b < NI + NO; b++) begin
            if (b < NI) in_uv[b] = 1'b1; else out_uv[b - NI] = 1'b1;
            tick(UVC - 1);
            in_uv = '0; out_uv = '0;
            tick(UVC + 2);
            chk($sformatf("R6 short uv bit%0d", b), int'(fault), 0);
            if (b < NI) in_uv[b] = 1'b1; else out_uv[b - NI] = 1'b1;
            tick(UVC);
            chk("R6 not yet", int'(fault), 0);
            tick(1);
            chk($sformatf("R7 uv bit%0d fault", b), int'(fault), 1);
            in_uv = '0; out_uv = '0;
            tick(UVC + 3);
            chk("R7 latched", int'(fault), 1);
            shdn = 1;
            tick(1);
            chk("R8 fault cleared", int'(fault), 0);
            chk("R8 outputs off", int'(act | dual3 | mem | d5sb | ramp), 0);
            shdn = 0;
            tick(QC + 2);
            chk("R4 back active", int'(act), 1);
        end

        // R7 undervoltage in sleep is not armed
        slp3 = 0;
        tick(GLC + DLYC + 2);
        out_uv[0] = 1'b1;
        tick(3 * UVC);
        chk("R7 unarmed in sleep", int'(fault), 0);
        out_uv = '0;
        slp3 = 1;
        tick(GLC + QC + 3);
        chk("R4 active again", int'(act), 1);

        // R7 warning temperature, R11 standby loss clears
        otw = 1;
        tick(1);
        otw = 0;
        chk("R7 warn sets fault", int'(fault), 1);
        tick(3);
        chk("R7 warn latched", int'(fault), 1);
        por = 0;
        tick(1);
        chk("R11 por clears fault", int'(fault), 0);
        chk("R11 por off", int'(act), 0);
        por = 1;
        tick(QC + 2);
        chk("R4 active after por", int'(act), 1);

        // R9 critical temperature
        otc = 1;
        tick(1);
        chk("R9 rails off", int'(act | dual3 | mem | d5sb | ramp), 0);
        chk("R7 crit fault", int'(fault), 1);
        otc = 0;
        tick(QC + 2);
        chk("R9 recovers", int'(act), 1);
        chk("R7 still latched", int'(fault), 1);

        // R3 capture on shutdown exit, direct OFF to S3
        shdn = 1; slp3 = 0; d5 = 0;
        tick(GLC + 2);
        chk("R8 shdn off", int'(ramp), 0);
        shdn = 0;
        tick(2);
        chk("R3 OFF to S3 mem", int'(mem), 1);
        chk("R3 shdn exit capture", int'(d5sb), 0);
        d5 = 1;
        tick(2);
        chk("R3 still ignored", int'(d5sb), 0);
        slp3 = 1;
        tick(GLC + QC + 3);
        chk("R4 active final", int'(act), 1);

        // R4 restart on a bad supply cycle
        shdn = 1;
        tick(1);
        shdn = 0;
        tick(10);
        in_uv[1] = 1'b1;
        tick(1);
        in_uv = '0;
        tick(QC - 1);
        chk("R4 restarted count", int'(act), 0);
        tick(1);
        chk("R4 active after restart", int'(act), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule